// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data buses, A and B. It can carry live data from one bus to the other. It can also hold a snapshot of each bus and drive that snapshot later. Each bus has its own capture register, and each register is loaded on the rising edge of its own clock. For each transfer direction, a select input chooses between the live value arriving from the opposite bus and the stored copy of that opposite bus.

An active-low enable and a direction input decide which bus, if either, is driven. The tri-state pads are modelled as three separate ports per bus: a data input, a data output and an output enable. While both outputs are disabled the registers keep capturing, so the block can also serve as a pair of storage ports. The output path is purely combinational, so no clock stage sits between the selects or the enable and the pads.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The A register loads `a_in` on each rising edge of `clk_a` and holds its value between those edges.
- R2: The B register loads `b_in` on each rising edge of `clk_b` and holds its value between those edges.
- R3: When bus B is driven, `b_out` equals the live `a_in` if `sel_to_b` is 0, and the A register if `sel_to_b` is 1.
- R4: When bus A is driven, `a_out` equals the live `b_in` if `sel_to_a` is 0, and the B register if `sel_to_a` is 1.
- R5: With `en_n` = 0, `dir` = 1 sets `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 sets `a_oe` = 1 and `b_oe` = 0. At most one output enable is ever high.
- R6: With `en_n` = 1, both output enables are 0, and rising edges on `clk_a` and `clk_b` still load the registers.
- R7: An output whose enable is 0 carries the value zero.
- R8: A low `rst_n` clears each register to zero at that register's next rising clock edge (synchronous reset).
- R9: A change on `sel_to_b`, `sel_to_a`, `en_n`, `dir`, `a_in` or `b_in` shows on the outputs without any clock edge.
- R10: Each register samples only its own bus input port. The value the block drives onto a bus never enters that bus's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock for the A register |
| clk_b | input | 1 | Capture clock for the B register |
| rst_n | input | 1 | Synchronous active-low reset for both registers |
| a_in | input | W | Data received from bus A |
| b_in | input | W | Data received from bus B |
| sel_to_b | input | 1 | Source for bus B: 0 = live A, 1 = stored A |
| sel_to_a | input | 1 | Source for bus A: 0 = live B, 1 = stored B |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 = drive bus B, 0 = drive bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
The test covers each transfer mode in turn:
- live transfer in each direction;
- stored transfer in each direction, with the live input changed after capture so that a live path cannot be confused with a stored one;
- loading while both outputs are disabled, then reading the stored values back.

Input changes with no clock pulse show that the path has no register stage. Captures without a pulse show that the register holds. A capture made while the block drives a different value onto the same bus shows whether the register takes its input port or the driven output.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_t;

  function automatic drive_t decode_drive(input logic en_n, input logic dir);
    if (en_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/bx_store.sv
module bx_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1 for the A instance, R2 for the B instance
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (q == $past(d)));

  a_r8_reset: assert property (@(posedge clk)
    !rst_n |=> (q == '0));
endmodule

// File: rtl/bx_drive_ctl.sv
module bx_drive_ctl
  import bx_pkg::*;
(
  input  logic en_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  drive_t drv;

  always_comb begin
    drv  = decode_drive(en_n, dir);
    a_oe = (drv == DRV_A);
    b_oe = (drv == DRV_B);
  end

  always_comb begin
    if (!$isunknown({en_n, dir})) begin
      a_r5_onehot: assert ($onehot0({a_oe, b_oe}));
      if (en_n) begin
        a_r6_both_off: assert (!a_oe && !b_oe);
      end
    end
  end
endmodule

// File: rtl/bx_path_mux.sv
module bx_path_mux #(
  parameter int W = 8
) (
  input  logic         sel_held,
  input  logic         drive,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] out
);
  function automatic logic [W-1:0] pick(input logic s, input logic en,
                                        input logic [W-1:0] l, input logic [W-1:0] h);
    if (!en) return '0;
    return s ? h : l;
  endfunction

  always_comb out = pick(sel_held, drive, live, held);

  always_comb begin
    if (!$isunknown(drive) && !drive) begin
      a_r7_idle_zero: assert (out == '0);
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sel_to_b,
  input  logic         sel_to_a,
  input  logic         en_n,
  input  logic         dir,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] a_held;
  logic [W-1:0] b_held;
  logic         a_drive;
  logic         b_drive;

  // R10: each store takes only its own bus input port
  bx_store #(.W(W)) u_store_a (.clk(clk_a), .rst_n(rst_n), .d(a_in), .q(a_held));
  bx_store #(.W(W)) u_store_b (.clk(clk_b), .rst_n(rst_n), .d(b_in), .q(b_held));

  bx_drive_ctl u_ctl (.en_n(en_n), .dir(dir), .a_oe(a_drive), .b_oe(b_drive));

  bx_path_mux #(.W(W)) u_mux_b (.sel_held(sel_to_b), .drive(b_drive),
                                .live(a_in), .held(a_held), .out(b_out));
  bx_path_mux #(.W(W)) u_mux_a (.sel_held(sel_to_a), .drive(a_drive),
                                .live(b_in), .held(b_held), .out(a_out));

  assign a_oe = a_drive;
  assign b_oe = b_drive;
endmodule

// File: tb/test_bus_xcvr_reg.sv
`timescale 1ns/1ps
module test_bus_xcvr_reg;
  localparam int W = 8;

  typedef struct {
    logic         aoe;
    logic [W-1:0] aout;
    logic         boe;
    logic [W-1:0] bout;
    string        req;
  } item_t;

  logic clk = 0;
  always #2 clk = ~clk;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic sel_to_b = 0, sel_to_a = 0, en_n = 1, dir = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .sel_to_b(sel_to_b), .sel_to_a(sel_to_a), .en_n(en_n), .dir(dir),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  item_t q[$];
  int checks = 0, fails = 0, cycles = 0;
  logic [W-1:0] m_a = '0, m_b = '0;

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sab, input logic sba, input logic g, input logic d,
                      input logic pa, input logic pb, input string req);
    item_t it;
    @(negedge clk);
    a_in = a; b_in = b; sel_to_b = sab; sel_to_a = sba; en_n = g; dir = d;
    #0.5;
    if (pa) begin clk_a = 1; if (rst_n) m_a = a; else m_a = '0; end
    if (pb) begin clk_b = 1; if (rst_n) m_b = b; else m_b = '0; end
    it.boe  = !g && d;
    it.aoe  = !g && !d;
    it.bout = it.boe ? (sab ? m_a : a) : '0;
    it.aout = it.aoe ? (sba ? m_b : b) : '0;
    it.req  = req;
    q.push_back(it);
    @(posedge clk);
    #1 clk_a = 0; clk_b = 0;
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (a_oe !== e.aoe || b_oe !== e.boe || a_out !== e.aout || b_out !== e.bout) begin
        fails++;
        $display("FAIL %s: actual a_oe=%b a_out=%h b_oe=%b b_out=%h expected a_oe=%b a_out=%h b_oe=%b b_out=%h",
                 e.req, a_oe, a_out, b_oe, b_out, e.aoe, e.aout, e.boe, e.bout);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset with pulses on both clocks, then stored values must read zero
    step(8'hA5, 8'h5A, 1, 1, 1, 0, 1, 1, "R8");
    rst_n = 1;
    step(8'hA5, 8'h5A, 1, 1, 0, 1, 0, 0, "R8");
    step(8'hA5, 8'h5A, 1, 1, 0, 0, 0, 0, "R8");
    // R3 live path, R9 change without clocks
    step(8'h5A, 8'h00, 0, 0, 0, 1, 0, 0, "R3");
    step(8'hC3, 8'h00, 0, 0, 0, 1, 0, 0, "R9");
    // R1 capture then change the live input
    step(8'h3C, 8'h00, 0, 0, 0, 1, 1, 0, "R1");
    step(8'hFF, 8'h00, 1, 0, 0, 1, 0, 0, "R1");
    step(8'h12, 8'h00, 1, 0, 0, 1, 0, 0, "R1");
    // R4 live, R2 stored
    step(8'h00, 8'h96, 0, 0, 0, 0, 0, 0, "R4");
    step(8'h00, 8'h11, 0, 0, 0, 0, 0, 1, "R2");
    step(8'h00, 8'hEE, 0, 1, 0, 0, 0, 0, "R2");
    // R5 direction flip, R9 select toggle alone
    step(8'h00, 8'hEE, 1, 1, 0, 1, 0, 0, "R5");
    step(8'h00, 8'hEE, 0, 1, 0, 1, 0, 0, "R9");
    // R6/R7 disabled, registers still load
    step(8'h77, 8'h88, 1, 1, 1, 1, 1, 1, "R6");
    step(8'h77, 8'h88, 1, 1, 1, 0, 0, 0, "R7");
    step(8'h01, 8'h02, 1, 1, 0, 1, 0, 0, "R6");
    step(8'h01, 8'h02, 1, 1, 0, 0, 0, 0, "R6");
    // R10: capture on B while B is driven with stored A
    step(8'h01, 8'h21, 1, 1, 0, 1, 0, 1, "R10");
    step(8'h01, 8'h00, 1, 1, 0, 0, 0, 0, "R10");
    // R10: capture on A while A is driven with stored B
    step(8'h44, 8'h00, 1, 1, 0, 0, 1, 0, "R10");
    step(8'h00, 8'h00, 1, 1, 0, 1, 0, 0, "R10");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule